// File: doc/BRIEF.md
# Low-Power DRAM Power-State Controller

This block decides when a mobile-class DRAM leaves normal operation for one of four low-power states, and how it comes back. The states are a stopped clock, power-down with every bank closed, power-down with a row still open, and deep power-down. The system asks for a low-power state by holding an idle request and picks the kind with a mode selector. It ends the state with a wake request. The command sequencer reports whether a read or write burst is still in the pipeline and which banks hold an open row.

The block drives the memory clock-enable, a clock-run enable for the clock gate, and a small command override. It also drives a stall that holds the command sequencer back while the memory cannot take commands. Entry happens only after the idle request has been held, with entry allowed, for a programmable number of back-to-back cycles. On exit the clock is running and clock-enable is high again, and a fixed run of NOP cycles passes before the sequencer is released. Deep power-down destroys the array contents. After leaving it, the block raises a data-lost flag and asks for re-initialisation until the system confirms that initialisation is complete.

Top module: `lpdram_pwr_ctrl`

## Requirements
- R1: After reset the state code is 0 (active), `cke` and `clkRun` are 1, `cmdOut` is 0 (no override), `seqStall` is 0, and `dataLost` and `initReq` are 0.
- R2: Entry needs `idleThr` consecutive rising edges at which entry is allowed; an `idleThr` of 0 counts as 1. A single edge at which entry is not allowed restarts the count. The state changes at the edge that completes the count.
- R3: With `modeSel` = 0 the block enters clock stop (state code 1), in which `clkRun` is 0. Entry is never allowed while `burstBusy` is 1.
- R4: With `modeSel` = 1 the block enters power-down. The state code is 2 when `bankOpen` is all zero at the entry edge, and 3 otherwise. In both codes `cke` is 0.
- R5: In every state other than active, `seqStall` is 1 and `cmdOut` is 1 (NOP). In the active state `seqStall` is 0 and `cmdOut` is 0.
- R6: With `modeSel` = 2 the block enters deep power-down (state code 4, `cke` 0) only while `bankOpen` is all zero. `modeSel` = 3 never allows entry.
- R7: A wake request in a low-power state moves the block to the exit state (code 5) at the next edge. It stays there for `EXIT_CYCLES` cycles (default 2) with `clkRun` and `cke` at 1, `cmdOut` at 1 and `seqStall` at 1, and then returns to active. Requests arriving during exit are ignored.
- R8: While `sysWake` is 1, entry is not allowed, even when `sysIdle` is 1.
- R9: Leaving deep power-down sets `dataLost`. `initReq` is 1 whenever `dataLost` is 1 and the block is active. An `initDone` pulse in the active state clears both at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idleThr | input | IDLE_CNT_W | Consecutive eligible cycles required before entry |
| modeSel | input | 2 | Requested state: 0 clock stop, 1 power-down, 2 deep power-down, 3 none |
| sysIdle | input | 1 | System idle request |
| sysWake | input | 1 | System wake request |
| burstBusy | input | 1 | A read or write burst is still in the data pipeline |
| bankOpen | input | NUM_BANKS | One bit per bank holding an open row |
| initDone | input | 1 | Re-initialisation sequence has completed |
| cke | output | 1 | Memory clock-enable |
| clkRun | output | 1 | 1 lets the memory clock run; 0 gates it |
| cmdOut | output | 2 | Command override: 0 none, 1 NOP |
| seqStall | output | 1 | Holds the command sequencer |
| pwrState | output | 3 | Current state code |
| dataLost | output | 1 | Array contents lost in deep power-down |
| initReq | output | 1 | Re-initialisation requested |

## Verification
The wake request and the idle-entry countdown can land on the same edge. The bench holds both requests high together for many cycles and expects the block to stay active with the stall low. A second collision is between the entry count and a burst or an open bank that forbids the requested state. The bench keeps the blocking input asserted well past the threshold, then releases it and checks that entry takes exactly a full threshold count from that edge. That shows the count restarted and was not carried over.

// File: rtl/lpdram_pwr_pkg.sv
package lpdram_pwr_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_CLKSTOP = 3'd1,
    ST_PPD     = 3'd2,
    ST_APD     = 3'd3,
    ST_DPD     = 3'd4,
    ST_EXIT    = 3'd5
  } pwrState_t;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_NOP  = 2'd1;

  localparam logic [1:0] MODE_CLKSTOP = 2'd0;
  localparam logic [1:0] MODE_PD      = 2'd1;
  localparam logic [1:0] MODE_DPD     = 2'd2;
  localparam logic [1:0] MODE_NONE    = 2'd3;

  typedef struct packed {
    logic idleCntClr;
    logic idleCntInc;
    logic exitLoad;
    logic exitDec;
    logic lostSet;
    logic lostClr;
  } pwrStrobe_t;

endpackage

// File: rtl/lpdram_pwr_dp.sv
module lpdram_pwr_dp
  import lpdram_pwr_pkg::*;
#(
  parameter int IDLE_CNT_W  = 8,
  parameter int EXIT_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  pwrStrobe_t            strobe,
  input  logic [IDLE_CNT_W-1:0] idleThr,
  output logic                  idleReached,
  output logic                  exitDone,
  output logic                  dataLost
);

  localparam int EXIT_CNT_W = $clog2(EXIT_CYCLES + 1);
  localparam logic [EXIT_CNT_W-1:0] EXIT_LOAD = EXIT_CNT_W'(EXIT_CYCLES - 1);

  logic [IDLE_CNT_W-1:0] idleCnt;
  logic [IDLE_CNT_W:0]   thrEff;
  logic [IDLE_CNT_W:0]   cntNext;
  logic [EXIT_CNT_W-1:0] exitCnt;

  always_comb begin
    thrEff  = (idleThr == '0) ? (IDLE_CNT_W+1)'(1) : {1'b0, idleThr};
    cntNext = {1'b0, idleCnt} + (IDLE_CNT_W+1)'(1);
  end

  assign idleReached = (cntNext >= thrEff);
  assign exitDone    = (exitCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= '0;
    end else if (strobe.idleCntClr) begin
      idleCnt <= '0;
    end else if (strobe.idleCntInc) begin
      idleCnt <= cntNext[IDLE_CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exitCnt <= '0;
    end else if (strobe.exitLoad) begin
      exitCnt <= EXIT_LOAD;
    end else if (strobe.exitDec && exitCnt != '0) begin
      exitCnt <= exitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataLost <= 1'b0;
    end else if (strobe.lostSet) begin
      dataLost <= 1'b1;
    end else if (strobe.lostClr) begin
      dataLost <= 1'b0;
    end
  end

  // R7
  exit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exitCnt <= EXIT_LOAD);

endmodule

// File: rtl/lpdram_pwr_fsm.sv
module lpdram_pwr_fsm
  import lpdram_pwr_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           modeSel,
  input  logic                 sysIdle,
  input  logic                 sysWake,
  input  logic                 burstBusy,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 initDone,
  input  logic                 idleReached,
  input  logic                 exitDone,
  output pwrStrobe_t           strobe,
  output pwrState_t            state
);

  pwrState_t stateNext;
  pwrState_t target;
  logic      banksIdle;
  logic      eligible;

  assign banksIdle = (bankOpen == '0);

  always_comb begin
    eligible = sysIdle && !sysWake && !burstBusy && (modeSel != MODE_NONE)
               && ((modeSel != MODE_DPD) || banksIdle);
    case (modeSel)
      MODE_CLKSTOP: target = ST_CLKSTOP;
      MODE_PD:      target = banksIdle ? ST_PPD : ST_APD;
      default:      target = ST_DPD;
    endcase
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_ACTIVE: begin
        strobe.lostClr = initDone;
        if (eligible) begin
          if (idleReached) begin
            stateNext         = target;
            strobe.idleCntClr = 1'b1;
          end else begin
            strobe.idleCntInc = 1'b1;
          end
        end else begin
          strobe.idleCntClr = 1'b1;
        end
      end
      ST_CLKSTOP, ST_PPD, ST_APD, ST_DPD: begin
        if (sysWake) begin
          stateNext       = ST_EXIT;
          strobe.exitLoad = 1'b1;
          strobe.lostSet  = (state == ST_DPD);
        end
      end
      ST_EXIT: begin
        if (exitDone) stateNext = ST_ACTIVE;
        else          strobe.exitDec = 1'b1;
      end
      default: stateNext = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ACTIVE;
    else        state <= stateNext;
  end

  // R3
  clkstop_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLKSTOP && $past(state) == ST_ACTIVE) |-> !$past(burstBusy));

  // R4
  apd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_APD && $past(state) == ST_ACTIVE) |-> ($past(bankOpen) != '0));

  // R4
  ppd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PPD && $past(state) == ST_ACTIVE) |-> ($past(bankOpen) == '0));

  // R6
  dpd_banks_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DPD && $past(state) == ST_ACTIVE) |-> ($past(bankOpen) == '0));

  // R8
  wake_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && sysWake) |=> (state == ST_ACTIVE));

endmodule

// File: rtl/lpdram_pwr_ctrl.sv
module lpdram_pwr_ctrl
  import lpdram_pwr_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int IDLE_CNT_W  = 8,
  parameter int EXIT_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDLE_CNT_W-1:0] idleThr,
  input  logic [1:0]            modeSel,
  input  logic                  sysIdle,
  input  logic                  sysWake,
  input  logic                  burstBusy,
  input  logic [NUM_BANKS-1:0]  bankOpen,
  input  logic                  initDone,
  output logic                  cke,
  output logic                  clkRun,
  output logic [1:0]            cmdOut,
  output logic                  seqStall,
  output logic [2:0]            pwrState,
  output logic                  dataLost,
  output logic                  initReq
);

  pwrStrobe_t strobe;
  pwrState_t  state;
  logic       idleReached;
  logic       exitDone;

  lpdram_pwr_fsm #(.NUM_BANKS(NUM_BANKS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .modeSel     (modeSel),
    .sysIdle     (sysIdle),
    .sysWake     (sysWake),
    .burstBusy   (burstBusy),
    .bankOpen    (bankOpen),
    .initDone    (initDone),
    .idleReached (idleReached),
    .exitDone    (exitDone),
    .strobe      (strobe),
    .state       (state)
  );

  lpdram_pwr_dp #(.IDLE_CNT_W(IDLE_CNT_W), .EXIT_CYCLES(EXIT_CYCLES)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .idleThr     (idleThr),
    .idleReached (idleReached),
    .exitDone    (exitDone),
    .dataLost    (dataLost)
  );

  always_comb begin
    cke      = !(state == ST_PPD || state == ST_APD || state == ST_DPD);
    clkRun   = (state != ST_CLKSTOP);
    cmdOut   = (state == ST_ACTIVE) ? CMD_NONE : CMD_NOP;
    seqStall = (state != ST_ACTIVE);
    pwrState = state;
    initReq  = dataLost && (state == ST_ACTIVE);
  end

  // R7
  exit_nop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmdOut == CMD_NOP && seqStall));

  // R7
  clock_restart_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkRun) |-> (cmdOut == CMD_NOP && seqStall));

  // R5
  stall_when_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke || !clkRun) |-> seqStall);

  // R9
  lost_from_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataLost) |-> ($past(pwrState) == 3'd4));

endmodule

// File: tb/tb_lpdram_pwr_ctrl.sv
module tb_lpdram_pwr_ctrl;

  localparam int NB = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] idleThr = '0;
  logic [1:0]    modeSel = 2'd0;
  logic          sysIdle = 1'b0;
  logic          sysWake = 1'b0;
  logic          burstBusy = 1'b0;
  logic [NB-1:0] bankOpen = '0;
  logic          initDone = 1'b0;
  logic          cke, clkRun, seqStall, dataLost, initReq;
  logic [1:0]    cmdOut;
  logic [2:0]    pwrState;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  always #2.5 clk = ~clk;

  lpdram_pwr_ctrl #(.NUM_BANKS(NB), .IDLE_CNT_W(CW), .EXIT_CYCLES(2)) dut (
    .clk(clk), .rst_n(rst_n), .idleThr(idleThr), .modeSel(modeSel),
    .sysIdle(sysIdle), .sysWake(sysWake), .burstBusy(burstBusy),
    .bankOpen(bankOpen), .initDone(initDone), .cke(cke), .clkRun(clkRun),
    .cmdOut(cmdOut), .seqStall(seqStall), .pwrState(pwrState),
    .dataLost(dataLost), .initReq(initReq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks = nChecks + 1;
    if (act != exp) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyclesN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Wake from any low-power state and follow the exit sequence (R7, R5)
  task automatic doWake();
    sysIdle = 1'b0;
    sysWake = 1'b1;
    @(negedge clk);
    sysWake = 1'b0;
    chk("R7 exit state", pwrState, 5);
    chk("R7 exit cke", cke, 1);
    chk("R7 exit clkRun", clkRun, 1);
    chk("R7 exit cmd NOP", cmdOut, 1);
    chk("R5 exit stall", seqStall, 1);
    @(negedge clk);
    chk("R7 exit second cycle", pwrState, 5);
    @(negedge clk);
    chk("R7 back to active", pwrState, 0);
    chk("R5 active stall", seqStall, 0);
    chk("R5 active cmd", cmdOut, 0);
  endtask

  task automatic testReset();
    chk("R1 state", pwrState, 0);
    chk("R1 cke", cke, 1);
    chk("R1 clkRun", clkRun, 1);
    chk("R1 cmd", cmdOut, 0);
    chk("R1 stall", seqStall, 0);
    chk("R1 dataLost", dataLost, 0);
    chk("R1 initReq", initReq, 0);
  endtask

  task automatic testClockStop();
    idleThr = 8'd4; modeSel = 2'd0; sysIdle = 1'b1;
    cyclesN(3);
    chk("R2 not yet after 3", pwrState, 0);
    @(negedge clk);
    chk("R3 clock stop state", pwrState, 1);
    chk("R3 clkRun low", clkRun, 0);
    chk("R5 stall in clock stop", seqStall, 1);
    chk("R5 NOP in clock stop", cmdOut, 1);
    doWake();
    idleThr = 8'd0; sysIdle = 1'b1;
    @(negedge clk);
    chk("R2 zero threshold acts as one", pwrState, 1);
    doWake();
  endtask

  task automatic testBurstBlock();
    idleThr = 8'd2; modeSel = 2'd0; sysIdle = 1'b1; burstBusy = 1'b1;
    cyclesN(6);
    chk("R3 burst blocks entry", pwrState, 0);
    chk("R3 clock kept running", clkRun, 1);
    burstBusy = 1'b0;
    @(negedge clk);
    chk("R2 count restarted after burst", pwrState, 0);
    @(negedge clk);
    chk("R3 entry after burst end", pwrState, 1);
    doWake();
  endtask

  task automatic testWakePriority();
    idleThr = 8'd2; modeSel = 2'd1; sysIdle = 1'b1; sysWake = 1'b1;
    cyclesN(6);
    chk("R8 wake beats idle", pwrState, 0);
    chk("R8 no stall", seqStall, 0);
    sysWake = 1'b0; sysIdle = 1'b0;
    idleThr = 8'd4; modeSel = 2'd0; sysIdle = 1'b1;
    cyclesN(3);
    sysIdle = 1'b0;
    @(negedge clk);
    sysIdle = 1'b1;
    cyclesN(3);
    chk("R2 interruption restarts count", pwrState, 0);
    @(negedge clk);
    chk("R2 full count after restart", pwrState, 1);
    doWake();
  endtask

  task automatic testPowerDown();
    idleThr = 8'd1; modeSel = 2'd1; bankOpen = 4'b0000; sysIdle = 1'b1;
    @(negedge clk);
    chk("R4 precharge power-down", pwrState, 2);
    chk("R4 cke low in ppd", cke, 0);
    chk("R5 stall in ppd", seqStall, 1);
    doWake();
    bankOpen = 4'b0100; sysIdle = 1'b1;
    @(negedge clk);
    chk("R4 active power-down", pwrState, 3);
    chk("R4 cke low in apd", cke, 0);
    chk("R4 clock runs in apd", clkRun, 1);
    doWake();
    bankOpen = '0;
  endtask

  task automatic testDeep();
    idleThr = 8'd2; modeSel = 2'd3; sysIdle = 1'b1;
    cyclesN(6);
    chk("R6 mode 3 never enters", pwrState, 0);
    modeSel = 2'd2; bankOpen = 4'b1000;
    cyclesN(6);
    chk("R6 open bank blocks deep", pwrState, 0);
    bankOpen = '0;
    cyclesN(2);
    chk("R6 deep entered", pwrState, 4);
    chk("R6 cke low in deep", cke, 0);
    chk("R9 no loss before exit", dataLost, 0);
    sysIdle = 1'b0; sysWake = 1'b1;
    @(negedge clk);
    sysWake = 1'b0;
    chk("R9 lost set on exit", dataLost, 1);
    chk("R9 no init request during exit", initReq, 0);
    cyclesN(2);
    chk("R9 active after deep exit", pwrState, 0);
    chk("R9 init requested", initReq, 1);
    cyclesN(3);
    chk("R9 request held", initReq, 1);
    initDone = 1'b1;
    @(negedge clk);
    initDone = 1'b0;
    chk("R9 lost cleared", dataLost, 0);
    chk("R9 request cleared", initReq, 0);
  endtask

  initial begin
    cyclesN(3);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testClockStop();
    testBurstBlock();
    testWakePriority();
    testPowerDown();
    testDeep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule